// File: doc/BRIEF.md
# Register Data-Move Execute Unit

This block is the execute stage for the register-only data-movement operations of a processor that uses 16-bit opcodes. It holds eight 32-bit data registers and four condition flags: negative (N), zero (Z), overflow (V) and carry (C). Each cycle it can accept one opcode, qualified by a valid input. It decodes the opcode and finishes the operation on the next clock edge. It supports four operations:

- an immediate load of a sign-extended 8-bit constant;
- in-place sign extension of a data register;
- clearing a data register at byte, word or long width;
- a register-to-register move at byte, word or long width.

For every accepted opcode the unit raises one of two one-cycle strobes. The completion strobe comes with the cycle cost of the operation. The illegal strobe comes with a cost of zero, and in that case no register and no flag has changed. A separate combinational read port lets a testbench or a neighbouring stage observe any data register at any time.

Top module: `dmx_top`

## Requirements
- R1: While reset is asserted (rst_n low) and afterwards until the first operation, every data register reads zero, all four flags are 0, and the done and illegal strobes are 0.
- R2: An opcode with op_valid high at a rising edge produces exactly one of done or illegal high in the following cycle. A cycle without op_valid produces neither strobe and changes no register or flag, whatever op_code holds. Back-to-back opcodes are each accepted.
- R3: A move uses the pattern 00 ss ddd 000 000 rrr. Bits 13:12 are the size code: 1 = byte, 3 = word, 2 = long. Bits 11:9 name the destination, and bits 2:0 name the source data register. Any nonzero mode field (bits 8:6 or 5:3) makes the opcode illegal.
- R4: After a move, N equals the top bit of the moved operand at its size (bit 7, 15 or 31). Z is 1 exactly when the moved operand is zero at its size. V and C are 0.
- R5: A byte-size or word-size write to a data register leaves the bits above the written width unchanged.
- R6: The immediate load uses the pattern 0111 ddd0 iiiiiiii. It writes the 8-bit immediate, sign-extended to 32 bits, into register ddd. It sets N and Z from that value and clears V and C.
- R7: Sign extension uses the pattern 0100 1000 1s00 0rrr. With s = 0, bits 15:0 of register rrr become bit 7 repeated above bits 7:0, and bits 31:16 are kept. With s = 1, the whole register becomes bits 15:0 sign-extended to 32 bits. The flags are not changed.
- R8: Clear uses the pattern 0100 0010 ss00 0rrr, with ss = 0 byte, 1 word, 2 long. It writes zero at that width, sets Z, and clears N, V and C.
- R9: The following opcodes are illegal: a move with size code 0, a clear with size code 3, a move with a nonzero mode field, and any opcode matching none of the patterns above. An illegal opcode changes no register and no flag, raises illegal for one cycle, and reports a cost of 0.
- R10: The cost output, valid while done is high, is 6 for a long clear and 4 for every other operation.
- R11: rd_data always shows the current contents of the register selected by rd_sel, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies op_code for this cycle |
| op_code | input | 16 | Opcode to execute |
| rd_sel | input | 3 | Data register index for the observation port |
| rd_data | output | 32 | Contents of the selected data register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | One-cycle strobe: an opcode completed |
| illegal | output | 1 | One-cycle strobe: an opcode was rejected |
| cycles | output | 4 | Cycle cost of the completed opcode, 0 on illegal |

## Verification
The bench goes after partial-width writes into registers whose upper bits are nonzero. A design that wrote whole registers would zero or sign-fill those bits, and the read-back would differ. It also checks that N is taken from bit 7, 15 or 31 according to the move size, so a design that took the sign from the wrong bit would report the wrong N on a byte or word move. Sign extension is run after an operation that left N set, so a design that updated flags on extension would show N cleared. The bench runs undefined size codes, nonzero mode fields and unrelated opcodes after a known flag state, so a design that partly executed them would alter a register or the flags. It also checks the cost difference of a long clear, back-to-back issue, and opcodes presented without op_valid.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int DATA_W    = 32;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int IDX_W     = 3;
    localparam int NUM_REGS  = 1 << IDX_W;
    localparam int OP_W      = 16;
    localparam int IMM_W     = 8;
    localparam int COST_W    = 4;
    localparam logic [COST_W-1:0] COST_BASE   = COST_W'(4);
    localparam logic [COST_W-1:0] COST_CLR_LONG = COST_W'(6);

    typedef enum logic [2:0] {
        K_NONE, K_MOVE, K_LOADQ, K_SEXT, K_ZERO, K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        W_BYTE, W_WORD, W_LONG
    } width_e;

    typedef struct packed {
        kind_e              kind;
        width_e             width;
        logic [IDX_W-1:0]   tgt;
        logic [IDX_W-1:0]   srcr;
        logic [IMM_W-1:0]   imm;
    } decoded_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    function automatic logic [NUM_LANES-1:0] lanes_of(input width_e w);
        case (w)
            W_BYTE:  return NUM_LANES'(1);
            W_WORD:  return NUM_LANES'(3);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/dmx_decode.sv
module dmx_decode
    import dmx_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output decoded_t        dec
);
    logic modes_zero;

    always_comb begin
        modes_zero = (op[8:6] == 3'b000) && (op[5:3] == 3'b000);
        dec        = '{kind: K_BAD, width: W_LONG, tgt: op[2:0],
                       srcr: op[2:0], imm: op[7:0]};
        if (op[15:14] == 2'b00) begin
            dec.tgt = op[11:9];
            case (op[13:12])
                2'd1:    dec.width = W_BYTE;
                2'd3:    dec.width = W_WORD;
                default: dec.width = W_LONG;
            endcase
            if (op[13:12] != 2'd0 && modes_zero)
                dec.kind = K_MOVE;
        end else if (op[15:12] == 4'b0111 && !op[8]) begin
            dec.kind = K_LOADQ;
            dec.tgt  = op[11:9];
        end else if (op[15:7] == 9'b0100_1000_1 && op[5:3] == 3'b000) begin
            dec.kind  = K_SEXT;
            dec.width = op[6] ? W_LONG : W_WORD;
        end else if (op[15:8] == 8'h42 && op[5:3] == 3'b000) begin
            case (op[7:6])
                2'd0:    dec.width = W_BYTE;
                2'd1:    dec.width = W_WORD;
                default: dec.width = W_LONG;
            endcase
            if (op[7:6] != 2'd3)
                dec.kind = K_ZERO;
        end
    end
endmodule

// File: rtl/dmx_alu.sv
module dmx_alu
    import dmx_pkg::*;
(
    input  decoded_t            dec,
    input  logic [DATA_W-1:0]   src_val,
    input  logic [DATA_W-1:0]   tgt_val,
    output logic                wr_en,
    output logic [DATA_W-1:0]   wr_val,
    output logic                ccr_we,
    output ccr_t                ccr_new,
    output logic                bad,
    output logic [COST_W-1:0]   cost
);
    logic [DATA_W-1:0]    res;
    logic [NUM_LANES-1:0] lane_en;

    always_comb begin
        res     = '0;
        lane_en = '0;
        wr_en   = 1'b0;
        ccr_we  = 1'b0;
        ccr_new = '0;
        bad     = 1'b0;
        cost    = COST_BASE;
        case (dec.kind)
            K_MOVE: begin
                wr_en   = 1'b1;
                ccr_we  = 1'b1;
                res     = src_val;
                lane_en = lanes_of(dec.width);
                case (dec.width)
                    W_BYTE: begin
                        ccr_new.n = src_val[7];
                        ccr_new.z = (src_val[7:0] == '0);
                    end
                    W_WORD: begin
                        ccr_new.n = src_val[15];
                        ccr_new.z = (src_val[15:0] == '0);
                    end
                    default: begin
                        ccr_new.n = src_val[DATA_W-1];
                        ccr_new.z = (src_val == '0);
                    end
                endcase
            end
            K_LOADQ: begin
                wr_en     = 1'b1;
                ccr_we    = 1'b1;
                res       = {{(DATA_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
                lane_en   = '1;
                ccr_new.n = dec.imm[IMM_W-1];
                ccr_new.z = (dec.imm == '0);
            end
            K_SEXT: begin
                wr_en = 1'b1;
                if (dec.width == W_WORD) begin
                    res[15:0] = {{8{tgt_val[7]}}, tgt_val[7:0]};
                    lane_en   = lanes_of(W_WORD);
                end else begin
                    res     = {{(DATA_W-16){tgt_val[15]}}, tgt_val[15:0]};
                    lane_en = '1;
                end
            end
            K_ZERO: begin
                wr_en     = 1'b1;
                ccr_we    = 1'b1;
                lane_en   = lanes_of(dec.width);
                ccr_new.z = 1'b1;
                if (dec.width == W_LONG)
                    cost = COST_CLR_LONG;
            end
            default: begin
                bad  = 1'b1;
                cost = '0;
            end
        endcase
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign wr_val[l*LANE_W +: LANE_W] =
            lane_en[l] ? res[l*LANE_W +: LANE_W] : tgt_val[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/dmx_regfile.sv
module dmx_regfile
    import dmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [IDX_W-1:0]    a_idx,
    output logic [DATA_W-1:0]   a_data,
    input  logic [IDX_W-1:0]    b_idx,
    output logic [DATA_W-1:0]   b_data,
    input  logic [IDX_W-1:0]    t_idx,
    output logic [DATA_W-1:0]   t_data
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_comb begin
            regs_d[r] = regs_q[r];
            if (we && widx == IDX_W'(r))
                regs_d[r] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[r] <= '0;
            else        regs_q[r] <= regs_d[r];
        end
    end

    assign a_data = regs_q[a_idx];
    assign b_data = regs_q[b_idx];
    assign t_data = regs_q[t_idx];
endmodule

// File: rtl/dmx_top.sv
module dmx_top
    import dmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [15:0]         op_code,
    input  logic [2:0]          rd_sel,
    output logic [31:0]         rd_data,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_v,
    output logic                flag_c,
    output logic                done,
    output logic                illegal,
    output logic [3:0]          cycles
);
    typedef struct packed {
        ccr_t               ccr;
        logic               done;
        logic               bad;
        logic [COST_W-1:0]  cost;
    } state_t;

    state_t              st_d, st_q;
    decoded_t            dec;
    logic [DATA_W-1:0]   src_val, tgt_val, wr_val;
    logic                wr_en, ccr_we, bad;
    ccr_t                ccr_new;
    logic [COST_W-1:0]   cost;

    dmx_decode u_decode (
        .op  (op_code),
        .dec (dec)
    );

    dmx_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (op_valid && wr_en),
        .widx   (dec.tgt),
        .wdata  (wr_val),
        .a_idx  (dec.srcr),
        .a_data (src_val),
        .b_idx  (dec.tgt),
        .b_data (tgt_val),
        .t_idx  (rd_sel),
        .t_data (rd_data)
    );

    dmx_alu u_alu (
        .dec     (dec),
        .src_val (src_val),
        .tgt_val (tgt_val),
        .wr_en   (wr_en),
        .wr_val  (wr_val),
        .ccr_we  (ccr_we),
        .ccr_new (ccr_new),
        .bad     (bad),
        .cost    (cost)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = op_valid && !bad;
        st_d.bad  = op_valid && bad;
        st_d.cost = (op_valid && !bad) ? cost : '0;
        if (op_valid && ccr_we)
            st_d.ccr = ccr_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_n  = st_q.ccr.n;
    assign flag_z  = st_q.ccr.z;
    assign flag_v  = st_q.ccr.v;
    assign flag_c  = st_q.ccr.c;
    assign done    = st_q.done;
    assign illegal = st_q.bad;
    assign cycles  = st_q.cost;
endmodule

// File: rtl/dmx_checker.sv
module dmx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic       flag_n,
    input logic       flag_z,
    input logic       flag_v,
    input logic       flag_c,
    input logic       done,
    input logic       illegal,
    input logic [3:0] cycles
);
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (done != illegal));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!done && !illegal));

    assert_bad_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable({flag_n, flag_z, flag_v, flag_c}));

    assert_bad_no_cost_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (cycles == 4'd0));

    assert_cost_values_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles == 4'd4 || cycles == 4'd6));

    assert_vc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_v && !flag_c);

    assert_nz_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_n && flag_z));
endmodule

bind dmx_top dmx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .done     (done),
    .illegal  (illegal),
    .cycles   (cycles)
);

// File: tb/tb_dmx_top.sv
module tb_dmx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op_code = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        flag_n, flag_z, flag_v, flag_c, done, illegal;
    logic [3:0]  cycles;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dmx_top dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .rd_sel(rd_sel), .rd_data(rd_data), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .done(done), .illegal(illegal),
        .cycles(cycles)
    );

    typedef struct packed {
        logic [15:0] op;
        logic [2:0]  rs;
        logic [31:0] data;
        logic [3:0]  nzvc;
        logic        ill;
        logic [3:0]  cyc;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{16'h7285, 3'd1, 32'hFFFFFF85, 4'b1000, 1'b0, 4'd4, 8'd6},  // R6 negative
        '{16'h7400, 3'd2, 32'h00000000, 4'b0100, 1'b0, 4'd4, 8'd6},  // R6 zero
        '{16'h767F, 3'd3, 32'h0000007F, 4'b0000, 1'b0, 4'd4, 8'd6},  // R6 positive
        '{16'h1203, 3'd1, 32'hFFFFFF7F, 4'b0000, 1'b0, 4'd4, 8'd5},  // R5 byte move keeps upper
        '{16'h3202, 3'd1, 32'hFFFF0000, 4'b0100, 1'b0, 4'd4, 8'd5},  // R5 word move, Z
        '{16'h2801, 3'd4, 32'hFFFF0000, 4'b1000, 1'b0, 4'd4, 8'd3},  // R3 long move, N bit 31
        '{16'h1803, 3'd4, 32'hFFFF007F, 4'b0000, 1'b0, 4'd4, 8'd5},  // R5
        '{16'h4884, 3'd4, 32'hFFFF007F, 4'b0000, 1'b0, 4'd4, 8'd7},  // R7 byte->word keeps upper
        '{16'h7A80, 3'd5, 32'hFFFFFF80, 4'b1000, 1'b0, 4'd4, 8'd6},  // R6
        '{16'h48C4, 3'd4, 32'h0000007F, 4'b1000, 1'b0, 4'd4, 8'd7},  // R7 word->long, flags kept
        '{16'h7A90, 3'd5, 32'hFFFFFF90, 4'b1000, 1'b0, 4'd4, 8'd6},  // R6
        '{16'h1005, 3'd0, 32'h00000090, 4'b1000, 1'b0, 4'd4, 8'd4},  // R4 N from bit 7
        '{16'h4880, 3'd0, 32'h0000FF90, 4'b1000, 1'b0, 4'd4, 8'd7},  // R7 negative byte
        '{16'h3405, 3'd2, 32'h0000FF90, 4'b1000, 1'b0, 4'd4, 8'd4},  // R4 N from bit 15
        '{16'h48C2, 3'd2, 32'hFFFFFF90, 4'b1000, 1'b0, 4'd4, 8'd7},  // R7 negative word
        '{16'h7E81, 3'd7, 32'hFFFFFF81, 4'b1000, 1'b0, 4'd4, 8'd6},  // R6
        '{16'h4207, 3'd7, 32'hFFFFFF00, 4'b0100, 1'b0, 4'd4, 8'd8},  // R8 byte clear
        '{16'h4247, 3'd7, 32'hFFFF0000, 4'b0100, 1'b0, 4'd4, 8'd8},  // R8 word clear
        '{16'h4287, 3'd7, 32'h00000000, 4'b0100, 1'b0, 4'd6, 8'd10}, // R10 long clear cost
        '{16'h2607, 3'd3, 32'h00000000, 4'b0100, 1'b0, 4'd4, 8'd4},  // R4 long zero
        '{16'h767F, 3'd3, 32'h0000007F, 4'b0000, 1'b0, 4'd4, 8'd6},  // R6
        '{16'h0203, 3'd1, 32'hFFFF0000, 4'b0000, 1'b1, 4'd0, 8'd9},  // R9 move size 0
        '{16'h42C1, 3'd1, 32'hFFFF0000, 4'b0000, 1'b1, 4'd0, 8'd9},  // R9 clear size 3
        '{16'h220B, 3'd1, 32'hFFFF0000, 4'b0000, 1'b1, 4'd0, 8'd3},  // R3 nonzero mode
        '{16'hFFFF, 3'd1, 32'hFFFF0000, 4'b0000, 1'b1, 4'd0, 8'd9}   // R9 unknown pattern
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] o);
        @(negedge clk);
        op_code  = o;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    function automatic logic [43:0] pack_obs();
        return {rd_data, flag_n, flag_z, flag_v, flag_c, illegal, done, 2'b00, cycles};
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [43:0] exp_obs;
        repeat (3) @(negedge clk);
        // R1: state held under reset
        rd_sel = 3'd4;
        #1;
        chk(rd_data == 0 && !done && !illegal, "R1", "during reset",
            {rd_data, done, illegal}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            rd_sel = 3'(r);
            #1;
            chk(rd_data == 0, "R1", "register after reset", rd_data, 0);  // R11 read port
        end
        chk({flag_n, flag_z, flag_v, flag_c, done, illegal} == 0, "R1", "flags/strobes",
            {flag_n, flag_z, flag_v, flag_c, done, illegal}, 0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op);
            rd_sel = VECS[i].rs;
            #1;
            exp_obs = {VECS[i].data, VECS[i].nzvc, VECS[i].ill, !VECS[i].ill, 2'b00, VECS[i].cyc};
            chk(pack_obs() == exp_obs, $sformatf("R%0d", VECS[i].req),
                $sformatf("vector %0d op %h", i, VECS[i].op), pack_obs(), exp_obs);
        end

        // R2: opcode present without op_valid is ignored
        @(negedge clk);
        op_code = 16'h7E55;
        rd_sel  = 3'd7;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(rd_data == 0 && !done && !illegal && {flag_n, flag_z} == 2'b00, "R2",
            "no valid, no effect", {rd_data, done, illegal, flag_n, flag_z}, 0);

        // R2: back-to-back acceptance
        @(negedge clk);
        op_code  = 16'h7001;
        op_valid = 1'b1;
        rd_sel   = 3'd0;
        @(negedge clk);
        #1;
        chk(done && rd_data == 32'h1, "R2", "first of pair", {done, rd_data}, {1'b1, 32'h1});
        op_code = 16'h7002;
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk(done && rd_data == 32'h2 && cycles == 4, "R2", "second of pair",
            {done, rd_data, cycles}, {1'b1, 32'h2, 4'd4});
        @(negedge clk);
        #1;
        chk(!done && !illegal, "R2", "strobe drops", {done, illegal}, 0);

        // R11: combinational read of an untouched register
        rd_sel = 3'd6;
        #1;
        chk(rd_data == 0, "R11", "read port D6", rd_data, 0);
        rd_sel = 3'd5;
        #1;
        chk(rd_data == 32'hFFFFFF90, "R11", "read port D5", rd_data, 32'hFFFFFF90);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule